// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models a small serial EEPROM of 256 sixteen-bit words that a host drives entirely by bit-banging. The host never sees a clocked serial port. It writes a four-bit control value, and the block treats each write as a new level on chip select, serial clock and data in. Transitions are found by comparing the new value with the one written before it. The data-out level comes back on the read side of the same control value.

A transaction starts with a chip-select rising edge. A start bit follows, then a two-bit opcode and an eight-bit address, and then, depending on the opcode, sixteen data bits or one dummy bit. Writes are not committed when the last data bit arrives. They wait for the next chip-select rising edge, and they take effect only while the write-enable latch is set. The extended opcode uses the two top address bits to choose one of four actions: lock writes, unlock writes, write every word, or erase every word. A read loads the addressed word into a 17-bit shift register, and the word leaves one bit per falling serial-clock edge through the top bit.

Top module: `eep_serial_slave`

## Requirements
- R1: After reset the state machine is idle-null, the write-enable latch is clear, and the whole control readback is 0. A write command issued before any unlock leaves the memory unchanged.
- R2: Control value bit 0 is chip select, bit 1 is serial clock, bit 2 is data in and bit 3 is data out. Readback returns the last written bits 2..0, with bit 3 taken from bit 16 of the shift register. A written bit 3 is ignored.
- R3: Edges are judged only between consecutive host writes. Writing the same value again causes no action, so a command sent with every write duplicated gives the same result.
- R4: A chip-select rising edge outside the commit state returns to idle and abandons any partial command. In idle, serial-clock rising edges with data in low are ignored until a high start bit arrives.
- R5: Opcode 10 (read) takes the 8-bit address and one dummy bit, then loads the word and shows 0 on data out. Each of the next 16 serial-clock falling edges presents one word bit, most significant first.
- R6: Opcode 01 (write) takes 16 data bits, most significant first. The next chip-select rising edge stores them at the address when writes are enabled, and data out then reads 1.
- R7: While the write-enable latch is clear, single-word commits, write-all and erase-all leave the memory unchanged.
- R8: Opcode 00 with address bits 7:6 = 11 sets the write-enable latch, and with 00 it clears it. Both act straight after the eighth address bit and need no data bits.
- R9: Opcode 00 with address bits 7:6 = 01 fills every word with the 16 bits that follow. With 10 it fills every word with 0xFFFF. The following chip-select rising edge then also commits the shifted 16 bits at the full 8-bit address.
- R10: Opcode 11 takes 16 bits and then sets the addressed word to 0xFFFF on the next chip-select rising edge.
- R11: During a read, serial-clock rising edges do not move the shift register; only falling edges do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | One-cycle strobe: host writes the control value |
| host_wdata | input | 4 | Control value written by the host (bit0 CS, bit1 SK, bit2 DI, bit3 ignored) |
| host_rdata | output | 4 | Control readback: last CS/SK/DI written, bit 3 is data out |

## Verification
The hardest situation to reach is the erase-all path. It overwrites the whole array and then, on the closing chip-select edge, stores a second word at the full command address. The result is visible only by reading back both that address and unrelated ones. The bench issues erase-all and write-all with random trailing data and random low address bits, then reads several addresses, including the command address, against its own model. Duplicated writes, leading zero bits before the start bit, and a write abandoned part way through are driven as directed sequences, with random operations between them.

// File: rtl/eep_pkg.sv
package eep_pkg;
    localparam int CTRL_W = 4;
    localparam int BIT_CS = 0;
    localparam int BIT_SK = 1;
    localparam int BIT_DI = 2;
    localparam int BIT_DO = 3;
    localparam int OP_W   = 2;
    localparam int SUB_W  = 2;

    typedef enum logic [3:0] {
        ST_NULL,
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_EXT,
        ST_DATA,
        ST_DUMMY,
        ST_FILL,
        ST_READ,
        ST_COMMIT
    } eep_state_e;

    localparam logic [OP_W-1:0]  OP_EXT     = 2'b00;
    localparam logic [OP_W-1:0]  OP_WRITE   = 2'b01;
    localparam logic [OP_W-1:0]  OP_READ    = 2'b10;
    localparam logic [OP_W-1:0]  OP_FILL    = 2'b11;

    localparam logic [SUB_W-1:0] EXT_LOCK   = 2'b00;
    localparam logic [SUB_W-1:0] EXT_ALL    = 2'b01;
    localparam logic [SUB_W-1:0] EXT_ERASE  = 2'b10;
    localparam logic [SUB_W-1:0] EXT_UNLOCK = 2'b11;
endpackage

// File: rtl/eep_pins.sv
module eep_pins (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic [2:0] pins_in,
    output logic [2:0] pins_q,
    output logic       cs_rise,
    output logic       sk_rise,
    output logic       sk_fall,
    output logic       di
);
    import eep_pkg::*;

    logic [2:0] pins_d;

    always_comb begin
        pins_d  = host_wr ? pins_in : pins_q;
        cs_rise = host_wr && !pins_q[BIT_CS] && pins_in[BIT_CS];
        sk_rise = host_wr && !pins_q[BIT_SK] && pins_in[BIT_SK];
        sk_fall = host_wr && pins_q[BIT_SK] && !pins_in[BIT_SK];
        di      = pins_in[BIT_DI];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pins_q <= '0;
        else        pins_q <= pins_d;
    end
endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              put_en,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] put_addr,
    input  logic [DATA_W-1:0] put_data,
    input  logic [DATA_W-1:0] fill_data,
    input  logic [ADDR_W-1:0] get_addr,
    output logic [DATA_W-1:0] get_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words_q [DEPTH];

    always_ff @(posedge clk) begin
        if (fill_en) begin
            for (int i = 0; i < DEPTH; i++) words_q[i] <= fill_data;
        end else if (put_en) begin
            words_q[put_addr] <= put_data;
        end
    end

    assign get_data = words_q[get_addr];

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n) // R9
        !(put_en && fill_en));
endmodule

// File: rtl/eep_fsm.sv
module eep_fsm #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              cs_rise,
    input  logic              sk_rise,
    input  logic              sk_fall,
    input  logic              di,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              put_en,
    output logic              fill_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] put_data,
    output logic [DATA_W-1:0] fill_data,
    output logic              dout
);
    import eep_pkg::*;

    localparam int SR_W  = DATA_W + 1;
    localparam int CNT_W = $clog2(DATA_W + 1);

    typedef struct packed {
        eep_state_e        st;
        logic [SR_W-1:0]   sr;
        logic [CNT_W-1:0]  cnt;
        logic [OP_W-1:0]   op;
        logic [ADDR_W-1:0] addr;
        logic              wen;
    } fsm_t;

    fsm_t q, n;

    always_comb begin
        n         = q;
        put_en    = 1'b0;
        fill_en   = 1'b0;
        fill_data = '1;
        if (cs_rise) begin
            if (q.st == ST_COMMIT) begin
                put_en = q.wen;
                n.sr   = '1;
                n.st   = ST_NULL;
            end else begin
                n.st   = ST_IDLE;
            end
        end
        if (sk_rise) begin
            if (!(n.st inside {ST_NULL, ST_IDLE, ST_READ})) begin
                n.sr  = {n.sr[SR_W-2:0], di};
                n.cnt = n.cnt + CNT_W'(1);
            end
            case (n.st)
                ST_IDLE: if (di) begin
                    n.st  = ST_OPCODE;
                    n.cnt = '0;
                    n.sr  = '0;
                end
                ST_OPCODE: if (n.cnt == CNT_W'(OP_W)) begin
                    n.st  = ST_ADDR;
                    n.cnt = '0;
                    n.op  = n.sr[OP_W-1:0];
                end
                ST_ADDR: if (n.cnt == CNT_W'(ADDR_W)) begin
                    n.cnt  = '0;
                    n.addr = n.sr[ADDR_W-1:0];
                    case (n.op)
                        OP_EXT: begin
                            n.st = ST_EXT;
                            if (n.addr[ADDR_W-1 -: SUB_W] == EXT_LOCK) begin
                                n.wen = 1'b0;
                                n.st  = ST_NULL;
                            end else if (n.addr[ADDR_W-1 -: SUB_W] == EXT_UNLOCK) begin
                                n.wen = 1'b1;
                                n.st  = ST_NULL;
                            end
                        end
                        OP_WRITE: n.st = ST_DATA;
                        OP_READ:  n.st = ST_DUMMY;
                        default:  n.st = ST_FILL;
                    endcase
                end
                ST_EXT: if (n.cnt == CNT_W'(DATA_W)) begin
                    case (n.addr[ADDR_W-1 -: SUB_W])
                        EXT_LOCK: begin
                            n.wen = 1'b0;
                            n.st  = ST_NULL;
                        end
                        EXT_ALL: begin
                            n.st      = ST_COMMIT;
                            fill_en   = n.wen;
                            fill_data = n.sr[DATA_W-1:0];
                        end
                        EXT_ERASE: begin
                            n.st      = ST_COMMIT;
                            fill_en   = n.wen;
                        end
                        default: begin
                            n.wen = 1'b1;
                            n.st  = ST_NULL;
                        end
                    endcase
                end
                ST_DATA: if (n.cnt == CNT_W'(DATA_W)) begin
                    n.cnt = '0;
                    n.st  = ST_COMMIT;
                end
                ST_DUMMY: if (n.cnt == CNT_W'(1)) begin
                    n.sr  = {1'b0, mem_rdata};
                    n.cnt = '0;
                    n.st  = ST_READ;
                end
                ST_FILL: if (n.cnt == CNT_W'(DATA_W)) begin
                    n.sr  = SR_W'({DATA_W{1'b1}});
                    n.cnt = '0;
                    n.st  = ST_COMMIT;
                end
                default: ;
            endcase
        end else if (sk_fall && n.st == ST_READ) begin
            n.sr  = {n.sr[SR_W-2:0], 1'b0};
            n.cnt = n.cnt + CNT_W'(1);
            if (n.cnt == CNT_W'(DATA_W)) begin
                n.cnt = '0;
                n.st  = ST_NULL;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= ST_NULL;
            q.sr   <= '0;
            q.cnt  <= '0;
            q.op   <= '0;
            q.addr <= '0;
            q.wen  <= 1'b0;
        end else begin
            q <= n;
        end
    end

    assign mem_addr = q.addr;
    assign put_data = q.sr[DATA_W-1:0];
    assign dout     = q.sr[SR_W-1];

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n) // R3
        !host_wr |=> ($stable(q.st) && $stable(q.sr) && $stable(q.wen)));

    AST_COMMIT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n) // R6
        (host_wr && cs_rise && q.st == ST_COMMIT) |=> (q.st == ST_NULL && (&q.sr)));

    AST_READ_RISE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) // R11
        (host_wr && sk_rise && !cs_rise && q.st == ST_READ) |=> $stable(q.sr));

    AST_READ_LOAD: assert property (@(posedge clk) disable iff (!rst_n) // R5
        (host_wr && sk_rise && !cs_rise && q.st == ST_DUMMY) |=> (q.st == ST_READ && !dout));

    AST_WEN_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) // R8
        !(q.st inside {ST_ADDR, ST_EXT}) |=> $stable(q.wen));
endmodule

// File: rtl/eep_serial_slave.sv
module eep_serial_slave #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic [3:0] host_wdata,
    output logic [3:0] host_rdata
);
    import eep_pkg::*;

    logic [2:0]        pins_q;
    logic              cs_rise, sk_rise, sk_fall, di, dout;
    logic              put_en, fill_en;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] put_data, fill_data, mem_rdata;
    logic              unused_do;

    assign unused_do = host_wdata[BIT_DO];

    eep_pins u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .host_wr (host_wr),
        .pins_in (host_wdata[2:0]),
        .pins_q  (pins_q),
        .cs_rise (cs_rise),
        .sk_rise (sk_rise),
        .sk_fall (sk_fall),
        .di      (di)
    );

    eep_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr   (host_wr),
        .cs_rise   (cs_rise),
        .sk_rise   (sk_rise),
        .sk_fall   (sk_fall),
        .di        (di),
        .mem_rdata (mem_rdata),
        .put_en    (put_en),
        .fill_en   (fill_en),
        .mem_addr  (mem_addr),
        .put_data  (put_data),
        .fill_data (fill_data),
        .dout      (dout)
    );

    eep_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .put_en    (put_en),
        .fill_en   (fill_en),
        .put_addr  (mem_addr),
        .put_data  (put_data),
        .fill_data (fill_data),
        .get_addr  (mem_addr),
        .get_data  (mem_rdata)
    );

    always_comb begin
        host_rdata         = '0;
        host_rdata[BIT_CS] = pins_q[BIT_CS];
        host_rdata[BIT_SK] = pins_q[BIT_SK];
        host_rdata[BIT_DI] = pins_q[BIT_DI];
        host_rdata[BIT_DO] = dout;
    end
endmodule

// File: tb/eep_serial_slave_test.sv
`timescale 1ns/1ps
module eep_serial_slave_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [3:0] host_wdata = 4'h0;
    logic [3:0] host_rdata;

    always #2.5 clk = ~clk;

    eep_serial_slave uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit dup    = 1'b0;
    int lead0  = 0;
    logic [15:0] mem_m [256];
    bit we_m = 1'b0;

    function automatic logic [15:0] exp_word(logic [7:0] a);
        return mem_m[a];
    endfunction

    function automatic logic [7:0] ext_addr(logic [1:0] sub, logic [5:0] lo);
        return {sub, lo};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic wr(bit cs, bit sk, bit di);
        int reps = dup ? 2 : 1;
        for (int i = 0; i < reps; i++) begin
            @(negedge clk);
            host_wr       = 1'b1;
            host_wdata[0] = cs;
            host_wdata[1] = sk;
            host_wdata[2] = di;
            host_wdata[3] = 1'($urandom);
            @(negedge clk);
            host_wr = 1'b0;
        end
    endtask

    task automatic send_bit(bit b);
        wr(1'b1, 1'b0, b);
        wr(1'b1, 1'b1, b);
    endtask

    task automatic send_bits(logic [15:0] v, int nb);
        for (int i = nb - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic start_cmd(logic [1:0] op, logic [7:0] a);
        wr(1'b0, 1'b0, 1'b0);
        wr(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < lead0; i++) send_bit(1'b0);
        send_bit(1'b1);
        send_bits({14'd0, op}, 2);
        send_bits({8'd0, a}, 8);
    endtask

    task automatic close_commit(string req);
        wr(1'b0, 1'b0, 1'b0);
        wr(1'b1, 1'b0, 1'b0);
        chk({req, " R6 data-out after commit"}, host_rdata[3], 1'b1);
        wr(1'b0, 1'b0, 1'b0);
    endtask

    task automatic op_write(logic [7:0] a, logic [15:0] d);
        start_cmd(2'b01, a);
        send_bits(d, 16);
        close_commit("write");
        if (we_m) mem_m[a] = d;
    endtask

    task automatic op_fill(logic [7:0] a);
        start_cmd(2'b11, a);
        send_bits(16'($urandom), 16);
        close_commit("R10 fill");
        if (we_m) mem_m[a] = 16'hFFFF;
    endtask

    task automatic op_wen(bit en);
        start_cmd(2'b00, ext_addr(en ? 2'b11 : 2'b00, 6'($urandom)));
        wr(1'b0, 1'b0, 1'b0);
        we_m = en;
    endtask

    task automatic op_all(bit erase, logic [15:0] d);
        logic [7:0] a = ext_addr(erase ? 2'b10 : 2'b01, 6'($urandom));
        start_cmd(2'b00, a);
        send_bits(d, 16);
        close_commit("R9 bulk");
        if (we_m) begin
            for (int i = 0; i < 256; i++) mem_m[i] = erase ? 16'hFFFF : d;
            mem_m[a] = d;
        end
    endtask

    task automatic op_read(logic [7:0] a, string req);
        logic [15:0] word = '0;
        start_cmd(2'b10, a);
        send_bit(1'($urandom));
        chk({req, " R5 data-out 0 after load"}, host_rdata[3], 1'b0);
        for (int k = 0; k < 16; k++) begin
            wr(1'b1, 1'b0, 1'b0);
            word = {word[14:0], host_rdata[3]};
            wr(1'b1, 1'b1, 1'b0);
            chk({req, " R11 rise holds data-out"}, host_rdata[3], word[0]);
        end
        wr(1'b0, 1'b0, 1'b0);
        chk({req, " R5 read word"}, word, exp_word(a));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        we_m = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20241));
        for (int i = 0; i < 256; i++) mem_m[i] = 16'h0;
        do_reset();
        chk("R1 readback after reset", host_rdata, 4'h0);

        wr(1'b1, 1'b1, 1'b1);
        chk("R2 readback fields, written data-out ignored", host_rdata, 4'b0111);
        wr(1'b0, 1'b0, 1'b0);
        chk("R2 readback after clear", host_rdata, 4'b0000);

        op_wen(1'b1);
        op_all(1'b0, 16'h1234);
        op_read(8'h05, "R9 write-all");
        op_read(8'hF0, "R9 write-all far");
        do_reset();
        op_write(8'h05, 16'hBEEF);
        op_read(8'h05, "R1 write-enable clear at reset");

        op_wen(1'b1);
        op_write(8'h05, 16'hBEEF);
        op_read(8'h05, "R6 write");
        op_wen(1'b0);
        op_write(8'h05, 16'h0000);
        op_fill(8'h05);
        op_read(8'h05, "R7 R8 locked write and fill");
        op_all(1'b1, 16'h5A5A);
        op_read(8'h05, "R7 locked erase");

        op_wen(1'b1);
        op_all(1'b1, 16'h0C3C);
        op_read(8'h05, "R9 erase-all");
        op_read(8'h80, "R9 erase-all low");
        op_write(8'h09, 16'h0F0F);
        op_fill(8'h09);
        op_read(8'h09, "R10 single fill");

        dup = 1'b1;
        op_write(8'h33, 16'hA5A5);
        op_read(8'h33, "R3 duplicated writes");
        dup = 1'b0;

        lead0 = 3;
        op_write(8'h44, 16'h1357);
        op_read(8'h44, "R4 leading zeros in idle");
        lead0 = 0;
        start_cmd(2'b01, 8'h44);
        send_bits(16'h00FF, 8);
        op_read(8'h44, "R4 aborted write");

        for (int it = 0; it < 180; it++) begin
            int sel = int'($urandom % 16);
            logic [7:0] a = 8'($urandom);
            if (sel < 6)       op_write(a, 16'($urandom));
            else if (sel < 11) op_read(a, "R5 random read");
            else if (sel < 12) op_fill(a);
            else if (sel < 13) op_wen(1'b0);
            else if (sel < 15) op_wen(1'b1);
            else               op_all(1'($urandom), 16'($urandom));
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule